// File: doc/BRIEF.md
# Indexed Video Register Port

This block is the host-facing register file of a display controller. It sits in a small I/O window of up to sixteen byte offsets. The host first writes a register number to the index port at offset 0. It then reads or writes the chosen register through the value port at offset 1. The register number stays latched, so any number of value-port accesses in a row all land on the same register.

The register space has three parts, each with a different storage behaviour:

- **Dense control registers** (numbers 0 to 45). These hold the device identifier, the enable flag, the display mode and several read-only constants.
- **Colour table** (numbers 1024 to 1791). It has 256 colours of three components each, and every entry is 8 bits wide.
- **Scratch words**. These start directly after the colour table, and their count is a parameter.

The driver must negotiate the device version through the identifier register before it can turn the device on. An identifier is the magic prefix 0x900000 shifted up by eight bits, OR'ed with a version number. The all-ones word is never accepted.

Version negotiation is a three-state machine with these states:

| State | Meaning | ID register reads |
|-------|---------|-------------------|
| `VS_UNSET` | Reset state; no identifier written yet | Highest supported identifier |
| `VS_AGREED` | A supported identifier was written | The accepted identifier |
| `VS_REFUSED` | An unsupported identifier was written | Highest supported identifier |

It has two transitions, and both can be taken from any state:

- **accept**: a write of a supported identifier moves the machine to `VS_AGREED`.
- **refuse**: a write of any other value moves it to `VS_REFUSED`.

Top module: `vidreg_port`

## Requirements
- R1: After reset the index port reads 0, `dev_en` is 0, the mode outputs are 0, and register 0 reads 0x90000002 (the highest supported identifier).
- R2: The index port reads back the last index written to it. The index holds until it is rewritten, so consecutive value-port reads return the same register.
- R3: Writing 0x90000000 | v to register 0, with v no greater than the supported maximum (2), is accepted: register 0 then reads back that word.
- R4: Any other write to register 0 is refused. Examples are 0xFFFFFFFF, 0x90000003 and 0x91000001. After a refusal, register 0 reads 0x90000002 and `dev_en` drops to 0 on the next cycle.
- R5: Register 1, bit 0, is the enable flag and drives `dev_en`. Writes to it take effect only in the `VS_AGREED` state and are ignored before negotiation or after a refusal.
- R6: The mode registers are width (2) and height (3), which are 32 bits each, and bits-per-pixel (7), which keeps the low 8 bits. Each one reads back and drives its output one cycle after the write.
- R7: Maximum width (4, reads 2560), maximum height (5, reads 1600) and scratch count (29, reads 16) are read-only, and writes to them are ignored.
- R8: The capability register (17) returns the configured word AND'ed with the defined-bit mask 0x003FC3E2, so unused bits read 0. The default configuration reads 0x00140002.
- R9: Register numbers 1024 to 1791 form the colour table. Each entry keeps the low 8 bits of the written word, reads back zero-extended, and is independent of the other entries.
- R10: Register numbers 1792 to 1807 are 32-bit scratch words that read back what was written.
- R11: Indices 46 to 1023 and indices at or above 1808 read 0, and writes to them are ignored.
- R12: Window offsets other than 0 and 1 read 0, and writes to them change neither the index nor any register.
- R13: A read strobe returns data on `io_rdata`, with `io_rvalid` high, exactly one cycle later. When a read and a write to the value port share a cycle, the read returns the value from before the write and the write still lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 4 | Offset within the I/O window |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid one cycle after `io_rd` |
| io_rvalid | output | 1 | High in the cycle that `io_rdata` holds a fresh read |
| dev_en | output | 1 | Device enabled |
| mode_width | output | 32 | Programmed display width |
| mode_height | output | 32 | Programmed display height |
| mode_bpp | output | 8 | Programmed bits per pixel |

## Verification
A read and a write strobe on the value port can fall in the same cycle. When they do, the read mux and the register update both act on the same register.

The bench provokes this by loading the width register with a known value. It then raises `io_rd` and `io_wr` together with a new value. It judges the result in two steps: the returned data must be the old width, and both a follow-up read and the `mode_width` port must show the new width. A second overlap pairs a refused identifier write with an active enable. It judges that the enable drops on the very next cycle.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

    // State of the version handshake.
    typedef enum logic [1:0] {
        VS_UNSET   = 2'd0,
        VS_AGREED  = 2'd1,
        VS_REFUSED = 2'd2
    } ver_state_e;

    // Which part of the register space an index falls into.
    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_PAL  = 2'd1,
        RG_SCR  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    localparam logic [23:0] ID_MAGIC    = 24'h900000;
    localparam logic [31:0] CAP_DEFINED = 32'h003F_C3E2;

    // Window offsets.
    localparam logic [3:0] OFF_INDEX = 4'd0;
    localparam logic [3:0] OFF_VALUE = 4'd1;

    // Control register numbers that are decoded.
    localparam logic [31:0] IX_ID   = 32'd0;
    localparam logic [31:0] IX_EN   = 32'd1;
    localparam logic [31:0] IX_W    = 32'd2;
    localparam logic [31:0] IX_H    = 32'd3;
    localparam logic [31:0] IX_MAXW = 32'd4;
    localparam logic [31:0] IX_MAXH = 32'd5;
    localparam logic [31:0] IX_BPP  = 32'd7;
    localparam logic [31:0] IX_CAPS = 32'd17;
    localparam logic [31:0] IX_SCRN = 32'd29;

endpackage

// File: rtl/vidreg_decode.sv
module vidreg_decode
    import vidreg_pkg::*;
#(
    parameter int CTRL_TOP = 46,
    parameter int PAL_BASE = 1024,
    parameter int PAL_N    = 768,
    parameter int SCR_N    = 16,
    localparam int PAL_AW  = $clog2(PAL_N),
    localparam int SCR_AW  = $clog2(SCR_N)
) (
    input  logic [31:0]       idx,
    output region_e           rg,
    output logic [PAL_AW-1:0] pal_a,
    output logic [SCR_AW-1:0] scr_a
);
    localparam int SCR_BASE = PAL_BASE + PAL_N;
    localparam int SCR_END  = SCR_BASE + SCR_N;

    always_comb begin
        pal_a = PAL_AW'(idx - 32'(PAL_BASE));
        scr_a = SCR_AW'(idx - 32'(SCR_BASE));
        if (idx < 32'(CTRL_TOP)) begin
            rg = RG_CTRL;
        end else if (idx >= 32'(PAL_BASE) && idx < 32'(SCR_BASE)) begin
            rg = RG_PAL;
        end else if (idx >= 32'(SCR_BASE) && idx < 32'(SCR_END)) begin
            rg = RG_SCR;
        end else begin
            rg = RG_NONE;
        end
    end

endmodule

// File: rtl/vidreg_version.sv
module vidreg_version
    import vidreg_pkg::*;
#(
    parameter int MAX_VER = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        id_wr,
    input  logic [31:0] id_wdata,
    output logic [31:0] id_rdata,
    output logic        agreed,
    output logic        id_bad
);
    localparam logic [7:0]  TOP_VER = 8'(MAX_VER);
    localparam logic [31:0] TOP_ID  = {ID_MAGIC, TOP_VER};

    ver_state_e  state_q, state_d;
    logic [31:0] id_q;
    logic        id_ok;

    assign id_ok  = (id_wdata[31:8] == ID_MAGIC) && (id_wdata[7:0] <= TOP_VER);
    assign id_bad = id_wr && !id_ok;

    // Next-state logic: accept / refuse.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_UNSET, VS_AGREED, VS_REFUSED: begin
                if (id_wr) state_d = id_ok ? VS_AGREED : VS_REFUSED;
            end
            default: state_d = VS_UNSET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VS_UNSET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             id_q <= TOP_ID;
        else if (id_wr && id_ok) id_q <= id_wdata;
    end

    // Output logic.
    always_comb begin
        unique case (state_q)
            VS_AGREED: begin
                id_rdata = id_q;
                agreed   = 1'b1;
            end
            default: begin
                id_rdata = TOP_ID;
                agreed   = 1'b0;
            end
        endcase
    end

    a_r3_accept_goes_agreed: assert property (@(posedge clk) disable iff (!rst_n)
        (id_wr && id_ok) |=> (state_q == VS_AGREED && id_q == $past(id_wdata)));

    a_r4_refuse_goes_refused: assert property (@(posedge clk) disable iff (!rst_n)
        id_bad |=> (state_q == VS_REFUSED));

    a_r3_agreed_has_magic: assert property (@(posedge clk) disable iff (!rst_n)
        agreed |-> (id_rdata[31:8] == ID_MAGIC && id_rdata[7:0] <= TOP_VER));

endmodule

// File: rtl/vidreg_store.sv
module vidreg_store #(
    parameter int PAL_N   = 768,
    parameter int PAL_W   = 8,
    parameter int SCR_N   = 16,
    parameter int DW      = 32,
    localparam int PAL_AW = $clog2(PAL_N),
    localparam int SCR_AW = $clog2(SCR_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pal_we,
    input  logic [PAL_AW-1:0] pal_a,
    input  logic [PAL_W-1:0]  pal_wd,
    output logic [PAL_W-1:0]  pal_rd,
    input  logic              scr_we,
    input  logic [SCR_AW-1:0] scr_a,
    input  logic [DW-1:0]     scr_wd,
    output logic [DW-1:0]     scr_rd
);
    logic [PAL_W-1:0] pal_mem [PAL_N];
    logic [DW-1:0]    scr_q   [SCR_N];

    always_ff @(posedge clk) begin
        if (pal_we) pal_mem[pal_a] <= pal_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SCR_N; i++) scr_q[i] <= '0;
        end else begin
            for (int i = 0; i < SCR_N; i++) begin
                if (scr_we && scr_a == SCR_AW'(i)) scr_q[i] <= scr_wd;
            end
        end
    end

    assign pal_rd = pal_mem[pal_a];
    assign scr_rd = scr_q[scr_a];

    a_r9_colour_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |=> (pal_mem[$past(pal_a)] == $past(pal_wd)));

    a_r10_scratch_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        scr_we |=> (scr_q[$past(scr_a)] == $past(scr_wd)));

endmodule

// File: rtl/vidreg_port.sv
module vidreg_port
    import vidreg_pkg::*;
#(
    parameter int          MAX_VER  = 2,
    parameter int          CTRL_TOP = 46,
    parameter int          PAL_BASE = 1024,
    parameter int          PAL_N    = 768,
    parameter int          PAL_W    = 8,
    parameter int          SCR_N    = 16,
    parameter int          MAX_W    = 2560,
    parameter int          MAX_H    = 1600,
    parameter logic [31:0] CAP_WORD = 32'h0014_0003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_rvalid,
    output logic        dev_en,
    output logic [31:0] mode_width,
    output logic [31:0] mode_height,
    output logic [7:0]  mode_bpp
);
    localparam int PAL_AW = $clog2(PAL_N);
    localparam int SCR_AW = $clog2(SCR_N);

    logic [31:0]       idx_q;
    region_e           rg;
    logic [PAL_AW-1:0] pal_a;
    logic [SCR_AW-1:0] scr_a;
    logic [PAL_W-1:0]  pal_rd;
    logic [31:0]       scr_rd;
    logic [31:0]       id_rdata;
    logic              agreed, id_bad;
    logic              idx_wr, val_wr, ctrl_wr, id_wr;
    logic              en_q;
    logic [31:0]       ctrl_rd, rd_mux;

    assign idx_wr  = io_wr && (io_addr == OFF_INDEX);
    assign val_wr  = io_wr && (io_addr == OFF_VALUE);
    assign ctrl_wr = val_wr && (rg == RG_CTRL);
    assign id_wr   = ctrl_wr && (idx_q == IX_ID);

    vidreg_decode #(
        .CTRL_TOP(CTRL_TOP), .PAL_BASE(PAL_BASE), .PAL_N(PAL_N), .SCR_N(SCR_N)
    ) u_dec (
        .idx(idx_q), .rg(rg), .pal_a(pal_a), .scr_a(scr_a)
    );

    vidreg_version #(.MAX_VER(MAX_VER)) u_ver (
        .clk(clk), .rst_n(rst_n), .id_wr(id_wr), .id_wdata(io_wdata),
        .id_rdata(id_rdata), .agreed(agreed), .id_bad(id_bad)
    );

    vidreg_store #(.PAL_N(PAL_N), .PAL_W(PAL_W), .SCR_N(SCR_N), .DW(32)) u_store (
        .clk(clk), .rst_n(rst_n),
        .pal_we(val_wr && rg == RG_PAL), .pal_a(pal_a),
        .pal_wd(io_wdata[PAL_W-1:0]), .pal_rd(pal_rd),
        .scr_we(val_wr && rg == RG_SCR), .scr_a(scr_a),
        .scr_wd(io_wdata), .scr_rd(scr_rd)
    );

    // Index latch and writable control registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            en_q        <= 1'b0;
            mode_width  <= '0;
            mode_height <= '0;
            mode_bpp    <= '0;
        end else begin
            if (idx_wr) idx_q <= io_wdata;
            if (id_bad) begin
                en_q <= 1'b0;
            end else if (ctrl_wr && idx_q == IX_EN && agreed) begin
                en_q <= io_wdata[0];
            end
            if (ctrl_wr && idx_q == IX_W)   mode_width  <= io_wdata;
            if (ctrl_wr && idx_q == IX_H)   mode_height <= io_wdata;
            if (ctrl_wr && idx_q == IX_BPP) mode_bpp    <= io_wdata[7:0];
        end
    end

    assign dev_en = en_q;

    always_comb begin
        unique case (idx_q)
            IX_ID:   ctrl_rd = id_rdata;
            IX_EN:   ctrl_rd = {31'b0, en_q};
            IX_W:    ctrl_rd = mode_width;
            IX_H:    ctrl_rd = mode_height;
            IX_MAXW: ctrl_rd = 32'(MAX_W);
            IX_MAXH: ctrl_rd = 32'(MAX_H);
            IX_BPP:  ctrl_rd = {24'b0, mode_bpp};
            IX_CAPS: ctrl_rd = CAP_WORD & CAP_DEFINED;
            IX_SCRN: ctrl_rd = 32'(SCR_N);
            default: ctrl_rd = '0;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        if (io_addr == OFF_INDEX) begin
            rd_mux = idx_q;
        end else if (io_addr == OFF_VALUE) begin
            unique case (rg)
                RG_CTRL: rd_mux = ctrl_rd;
                RG_PAL:  rd_mux = {{(32-PAL_W){1'b0}}, pal_rd};
                RG_SCR:  rd_mux = scr_rd;
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_rdata  <= '0;
            io_rvalid <= 1'b0;
        end else begin
            io_rvalid <= io_rd;
            if (io_rd) io_rdata <= rd_mux;
        end
    end

    a_r5_enable_needs_agree: assert property (@(posedge clk) disable iff (!rst_n)
        dev_en |-> agreed);

    a_r4_refusal_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        id_bad |=> !dev_en);

    a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx_q));

    a_r13_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> io_rvalid);

    a_r13_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> !io_rvalid);

endmodule

// File: tb/vidreg_port_tb_top.sv
module vidreg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_rvalid;
    logic        dev_en;
    logic [31:0] mode_width, mode_height;
    logic [7:0]  mode_bpp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vidreg_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .dev_en(dev_en), .mode_width(mode_width), .mode_height(mode_height),
        .mode_bpp(mode_bpp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
        checks++;
        if (io_rvalid !== 1'b1) begin
            errors++;
            $display("FAIL R13: rvalid actual %0b expected 1", io_rvalid);
        end
    endtask

    task automatic reg_wr(input logic [31:0] ix, input logic [31:0] d);
        wr(4'd0, ix);
        wr(4'd1, d);
    endtask

    task automatic reg_rd(input logic [31:0] ix, output logic [31:0] d);
        wr(4'd0, ix);
        rd(4'd1, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd0, v);           chk("R1 index", v, 32'd0);
        chk("R1 dev_en", {31'b0, dev_en}, 32'd0);
        chk("R1 width", mode_width, 32'd0);
        rd(4'd1, v);           chk("R1 id", v, 32'h9000_0002);
        @(negedge clk);
        chk("R13 rvalid low", {31'b0, io_rvalid}, 32'd0);
    endtask

    task automatic t_enable_unset;
        logic [31:0] v;
        reg_wr(32'd1, 32'd1);
        chk("R5 unset enable ignored", {31'b0, dev_en}, 32'd0);
        rd(4'd1, v);           chk("R5 unset enable reg", v, 32'd0);
    endtask

    task automatic t_index_hold;
        logic [31:0] v;
        reg_wr(32'd2, 32'h320);
        rd(4'd1, v);           chk("R2 first read", v, 32'h320);
        rd(4'd1, v);           chk("R2 second read", v, 32'h320);
        rd(4'd0, v);           chk("R2 index readback", v, 32'd2);
    endtask

    task automatic t_accept;
        logic [31:0] v;
        reg_wr(32'd0, 32'h9000_0001);
        rd(4'd1, v);           chk("R3 id v1", v, 32'h9000_0001);
        reg_wr(32'd0, 32'h9000_0000);
        rd(4'd1, v);           chk("R3 id v0", v, 32'h9000_0000);
        reg_wr(32'd1, 32'd1);
        chk("R5 enable after agree", {31'b0, dev_en}, 32'd1);
        rd(4'd1, v);           chk("R5 enable reg", v, 32'd1);
    endtask

    task automatic t_reject;
        logic [31:0] v;
        reg_wr(32'd0, 32'hFFFF_FFFF);
        chk("R4 enable dropped", {31'b0, dev_en}, 32'd0);
        rd(4'd1, v);           chk("R4 id all-ones", v, 32'h9000_0002);
        reg_wr(32'd1, 32'd1);
        chk("R5 refused enable ignored", {31'b0, dev_en}, 32'd0);
        reg_wr(32'd0, 32'h9000_0003);
        rd(4'd1, v);           chk("R4 id ver3", v, 32'h9000_0002);
        reg_wr(32'd0, 32'h9100_0001);
        rd(4'd1, v);           chk("R4 id bad magic", v, 32'h9000_0002);
        reg_wr(32'd0, 32'h9000_0002);
        rd(4'd1, v);           chk("R3 id v2", v, 32'h9000_0002);
    endtask

    task automatic t_modes;
        logic [31:0] v;
        reg_wr(32'd2, 32'd800);
        reg_wr(32'd3, 32'd600);
        reg_wr(32'd7, 32'h120);
        chk("R6 width out", mode_width, 32'd800);
        chk("R6 height out", mode_height, 32'd600);
        chk("R6 bpp out", {24'b0, mode_bpp}, 32'h20);
        reg_rd(32'd3, v);      chk("R6 height read", v, 32'd600);
        reg_rd(32'd7, v);      chk("R6 bpp read", v, 32'h20);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        reg_wr(32'd4, 32'd7);
        rd(4'd1, v);           chk("R7 max width", v, 32'd2560);
        reg_wr(32'd5, 32'd7);
        rd(4'd1, v);           chk("R7 max height", v, 32'd1600);
        reg_wr(32'd29, 32'd7);
        rd(4'd1, v);           chk("R7 scratch count", v, 32'd16);
        reg_wr(32'd17, 32'hFFFF_FFFF);
        rd(4'd1, v);           chk("R8 caps", v, 32'h0014_0002);
    endtask

    task automatic t_palette;
        logic [31:0] v;
        reg_wr(32'd1024, 32'h1AB);
        reg_wr(32'd1791, 32'h55);
        reg_rd(32'd1024, v);   chk("R9 first entry", v, 32'hAB);
        reg_rd(32'd1791, v);   chk("R9 last entry", v, 32'h55);
    endtask

    task automatic t_scratch;
        logic [31:0] v;
        reg_wr(32'd1792, 32'hDEAD_BEEF);
        reg_wr(32'd1807, 32'h1234_5678);
        reg_rd(32'd1792, v);   chk("R10 first scratch", v, 32'hDEAD_BEEF);
        reg_rd(32'd1807, v);   chk("R10 last scratch", v, 32'h1234_5678);
    endtask

    task automatic t_outside;
        logic [31:0] v;
        reg_wr(32'd46, 32'd5);
        rd(4'd1, v);           chk("R11 idx 46", v, 32'd0);
        reg_wr(32'd1023, 32'd5);
        rd(4'd1, v);           chk("R11 idx 1023", v, 32'd0);
        reg_wr(32'd1808, 32'd5);
        rd(4'd1, v);           chk("R11 idx 1808", v, 32'd0);
        reg_rd(32'hFFFF_FFFF, v); chk("R11 idx max", v, 32'd0);
        reg_rd(32'd1807, v);   chk("R11 neighbour untouched", v, 32'h1234_5678);
    endtask

    task automatic t_window;
        logic [31:0] v;
        wr(4'd0, 32'd2);
        wr(4'd2, 32'd9);
        wr(4'd8, 32'd9);
        rd(4'd2, v);           chk("R12 offset 2", v, 32'd0);
        rd(4'd8, v);           chk("R12 offset 8", v, 32'd0);
        rd(4'd0, v);           chk("R12 index kept", v, 32'd2);
        rd(4'd1, v);           chk("R12 width kept", v, 32'd800);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(4'd0, 32'd2);
        @(negedge clk);
        io_addr = 4'd1; io_wdata = 32'd1024; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk("R13 read-before-write data", io_rdata, 32'd800);
        chk("R13 collide rvalid", {31'b0, io_rvalid}, 32'd1);
        chk("R13 write landed", mode_width, 32'd1024);
        rd(4'd1, v);           chk("R13 follow-up read", v, 32'd1024);
        // enable, then refuse: enable drops next cycle
        reg_wr(32'd1, 32'd1);
        chk("R5 enable again", {31'b0, dev_en}, 32'd1);
        reg_wr(32'd0, 32'h8000_0002);
        chk("R4 refusal drops enable", {31'b0, dev_en}, 32'd0);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_unset();
        t_index_hold();
        t_accept();
        t_reject();
        t_modes();
        t_readonly();
        t_palette();
        t_scratch();
        t_outside();
        t_window();
        t_collide();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule